// File: doc/BRIEF.md
# Crosspoint Clock Router with Post-Dividers

This block distributes clocks. Four source clocks enter it: a reference and the outputs of three synthesizers. A crosspoint sends any source to any of four output channels. Each channel has a programmable 7-bit integer post-divider. A fifth output always divides the first synthesizer by 2, 3 or 4. All settings are static configuration inputs that the surrounding logic provides. Synthesis of the source clocks and the storage that holds the configuration are outside this block.

A 3-bit profile input comes from outside the chip and can change at any moment. It indexes an 8-entry map. Each map entry chooses divider register 0 or register 1, and that choice applies to the first two channels together. Each channel brings the choice into its own clock domain through a two-stage synchronizer. It then changes the divider only when the current output period ends, so no output pulse is ever shortened. Each channel can also take the inverted phase of its source. Two channels fed from the same source then toggle half a source period apart.

Top module: `clk_xpoint_router`

## Requirements
- R1: Channel k (k = 0..3, outputs A..D) is clocked by the source that field `route_cfg[2k+1:2k]` names: 0 is the reference `src_clk[0]`, and 1, 2 and 3 are synthesizers `src_clk[1..3]`.
- R2: With a divider value N from 2 to 127, the channel output period is N periods of its channel clock. N = 1 passes the channel clock straight through.
- R3: For even N the output is high for exactly N/2 channel-clock periods. For odd N of 3 or more, a falling-edge stage stretches the high phase to N/2 periods, so the duty cycle is 50 %.
- R4: A divider value of 0 switches the channel off, and its output stays low.
- R5: Bit `prof_map[prof_sel]` chooses divider register 1 (when 1) or register 0 (when 0). The choice applies to channels A and B together.
- R6: Channels C and D use their single divider values whatever the value of `prof_sel`.
- R7: A new divider value is loaded only at the last count of the current output period. While `prof_sel` is changing, every output period equals the whole old period or the whole new period.
- R8: Output `clk_e` divides `src_clk[1]` by 2 when `e_div_cfg` is 0, by 3 when it is 1, and by 4 when it is 2 or 3. Duty cycle is 50 %.
- R9: When `invert_cfg[k]` is 1, channel k counts on the inverted source. Its edges then fall half a source period away from those of a non-inverted channel on the same source.
- R10: While `rst_n` is low, all five outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 4 | Source clocks: bit 0 is the reference, bits 1 to 3 are the synthesizers |
| rst_n | input | 1 | Asynchronous active-low reset |
| prof_sel | input | 3 | External profile code, asynchronous to every clock |
| prof_map | input | 8 | Per-profile choice of divider register for channels A and B |
| route_cfg | input | 8 | Crosspoint: a 2-bit source number for each channel |
| invert_cfg | input | 4 | Per-channel selection of the inverted source phase |
| div_a0 | input | 7 | Channel A divider, register 0 |
| div_a1 | input | 7 | Channel A divider, register 1 |
| div_b0 | input | 7 | Channel B divider, register 0 |
| div_b1 | input | 7 | Channel B divider, register 1 |
| div_c | input | 7 | Channel C divider |
| div_d | input | 7 | Channel D divider |
| e_div_cfg | input | 2 | Ratio code for the fixed output |
| clk_out | output | 4 | Divided clocks for channels A to D |
| clk_e | output | 1 | First synthesizer divided by 2, 3 or 4 |

## Verification
Each source is routed in turn to channel A with a ratio of 2. Because the four source periods differ, a wrong crosspoint index shows up as a wrong output period. Ratios 1, 3, 4, 5 and 127 and all three fixed-output codes are each measured for high time and period; this separates pass-through, the odd-ratio half-cycle stretch and the counter width. Profile codes whose map bits differ check that A and B switch together while C keeps its period. A burst of `prof_sel` toggles while channel A runs tests that every period is a whole old period or a whole new one. Two channels on one source, one of them inverted, must show a half-source-period offset between their edges.

// File: rtl/clkrt_pkg.sv
`timescale 1ns/1ps
package clkrt_pkg;
  localparam int NSRC    = 4;
  localparam int NCH     = 4;
  localparam int DIVW    = 7;
  localparam int SELW    = 3;
  localparam int NPROF   = 1 << SELW;
  localparam int PROF_CH = 2;
  localparam int RTW     = $clog2(NSRC);
  localparam int EW      = 3;
endpackage

// File: rtl/clk_postdiv.sv
`timescale 1ns/1ps
// Integer clock divider. Its ratio reloads only when an output period ends.
module clk_postdiv #(
  parameter int W = 7
) (
  input  logic         clk_in,
  input  logic         rst_n,
  input  logic [W-1:0] div_val,
  output logic         clk_o
);
  logic [W-1:0] cur_n, cnt, cnt_nxt, n_nxt;
  logic         term, q_p, q_n, q_p_nxt, cur_odd;

  always_comb begin
    term    = (cur_n <= W'(1)) || (cnt == cur_n - W'(1));
    cnt_nxt = term ? '0 : cnt + W'(1);
    n_nxt   = term ? div_val : cur_n;
    q_p_nxt = (n_nxt >= W'(2)) && (cnt_nxt < (n_nxt >> 1));
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cur_n <= '0;
      cnt   <= '0;
      q_p   <= 1'b0;
    end else begin
      cur_n <= n_nxt;
      cnt   <= cnt_nxt;
      q_p   <= q_p_nxt;
    end
  end

  assign cur_odd = cur_n[0] && (cur_n >= W'(3));

  // Half-cycle stretch for odd ratios
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) q_n <= 1'b0;
    else        q_n <= q_p & cur_odd;
  end

  assign clk_o = (cur_n == W'(1)) ? clk_in : (q_p | q_n);

  a_r2_cnt_in_range: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cur_n >= W'(2)) |-> (cnt < cur_n));
  a_r4_off_is_low: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cur_n == '0) |-> (clk_o == 1'b0));
  a_r7_load_at_term: assert property (@(posedge clk_in) disable iff (!rst_n)
    (cur_n != $past(cur_n)) |-> $past(term));
  a_r3_stretch_odd_only: assert property (@(posedge clk_in) disable iff (!rst_n)
    q_n |-> cur_odd);
endmodule

// File: rtl/clk_route_channel.sv
`timescale 1ns/1ps
// One crosspoint leg: source pick, optional inversion, register-choice sync, divider.
module clk_route_channel
  import clkrt_pkg::*;
#(
  parameter int W = DIVW
) (
  input  logic [NSRC-1:0] src_clk,
  input  logic            rst_n,
  input  logic [RTW-1:0]  route,
  input  logic            inv,
  input  logic            reg_pick,
  input  logic [W-1:0]    div0,
  input  logic [W-1:0]    div1,
  output logic            clk_o
);
  logic         ch_clk, pick_m, pick_s;
  logic [W-1:0] div_sel;

  assign ch_clk = src_clk[route] ^ inv;

  always_ff @(posedge ch_clk or negedge rst_n) begin
    if (!rst_n) begin
      pick_m <= 1'b0;
      pick_s <= 1'b0;
    end else begin
      pick_m <= reg_pick;
      pick_s <= pick_m;
    end
  end

  assign div_sel = pick_s ? div1 : div0;

  clk_postdiv #(.W(W)) u_div (
    .clk_in (ch_clk),
    .rst_n  (rst_n),
    .div_val(div_sel),
    .clk_o  (clk_o)
  );

  a_r5_pick_two_stage: assert property (@(posedge ch_clk) disable iff (!rst_n)
    (pick_s != $past(pick_s)) |-> (pick_s == $past(pick_m)));
endmodule

// File: rtl/clk_xpoint_router.sv
`timescale 1ns/1ps
module clk_xpoint_router
  import clkrt_pkg::*;
(
  input  logic [NSRC-1:0]     src_clk,
  input  logic                rst_n,
  input  logic [SELW-1:0]     prof_sel,
  input  logic [NPROF-1:0]    prof_map,
  input  logic [NCH*RTW-1:0]  route_cfg,
  input  logic [NCH-1:0]      invert_cfg,
  input  logic [DIVW-1:0]     div_a0,
  input  logic [DIVW-1:0]     div_a1,
  input  logic [DIVW-1:0]     div_b0,
  input  logic [DIVW-1:0]     div_b1,
  input  logic [DIVW-1:0]     div_c,
  input  logic [DIVW-1:0]     div_d,
  input  logic [1:0]          e_div_cfg,
  output logic [NCH-1:0]      clk_out,
  output logic                clk_e
);
  logic            prof_pick;
  logic [DIVW-1:0] div0_arr [NCH];
  logic [DIVW-1:0] div1_arr [NCH];
  logic [EW-1:0]   e_ratio;

  assign prof_pick = prof_map[prof_sel];

  // Channels C and D have one register each, so the same value goes to both slots
  assign div0_arr[0] = div_a0;
  assign div1_arr[0] = div_a1;
  assign div0_arr[1] = div_b0;
  assign div1_arr[1] = div_b1;
  assign div0_arr[2] = div_c;
  assign div1_arr[2] = div_c;
  assign div0_arr[3] = div_d;
  assign div1_arr[3] = div_d;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic pick_ch;
    assign pick_ch = (ch < PROF_CH) ? prof_pick : 1'b0;

    clk_route_channel #(.W(DIVW)) u_ch (
      .src_clk (src_clk),
      .rst_n   (rst_n),
      .route   (route_cfg[ch*RTW +: RTW]),
      .inv     (invert_cfg[ch]),
      .reg_pick(pick_ch),
      .div0    (div0_arr[ch]),
      .div1    (div1_arr[ch]),
      .clk_o   (clk_out[ch])
    );
  end

  always_comb begin
    case (e_div_cfg)
      2'd0:    e_ratio = EW'(2);
      2'd1:    e_ratio = EW'(3);
      default: e_ratio = EW'(4);
    endcase
  end

  clk_postdiv #(.W(EW)) u_ediv (
    .clk_in (src_clk[1]),
    .rst_n  (rst_n),
    .div_val(e_ratio),
    .clk_o  (clk_e)
  );
endmodule

// File: tb/clk_xpoint_router_tb_top.sv
`timescale 1ns/1ps
module clk_xpoint_router_tb_top;
  logic [3:0] src_clk = 4'b0000;
  logic       rst_n = 1'b0;
  logic [2:0] prof_sel = 3'd0;
  logic [7:0] prof_map = 8'h00;
  logic [7:0] route_cfg = 8'h00;
  logic [3:0] invert_cfg = 4'h0;
  logic [6:0] div_a0 = 7'd2, div_a1 = 7'd2, div_b0 = 7'd2, div_b1 = 7'd2;
  logic [6:0] div_c = 7'd2, div_d = 7'd2;
  logic [1:0] e_div_cfg = 2'd0;
  logic [3:0] clk_out;
  logic       clk_e;

  // Source periods (ns): reference 4 (250 MHz), synth1 6, synth2 10, synth3 8
  always #2.0 src_clk[0] = ~src_clk[0];
  always #3.0 src_clk[1] = ~src_clk[1];
  always #5.0 src_clk[2] = ~src_clk[2];
  always #4.0 src_clk[3] = ~src_clk[3];

  clk_xpoint_router dut_i (
    .src_clk(src_clk), .rst_n(rst_n), .prof_sel(prof_sel), .prof_map(prof_map),
    .route_cfg(route_cfg), .invert_cfg(invert_cfg),
    .div_a0(div_a0), .div_a1(div_a1), .div_b0(div_b0), .div_b1(div_b1),
    .div_c(div_c), .div_d(div_d), .e_div_cfg(e_div_cfg),
    .clk_out(clk_out), .clk_e(clk_e)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Scoreboard queues filled by the driver, drained by the monitor
  int    q_idx[$];
  real   q_hi[$];
  real   q_per[$];
  string q_tag[$];
  int    pend = 0;

  int   mon_idx = 0;
  logic mon_sig;
  assign mon_sig = (mon_idx == 4) ? clk_e : clk_out[mon_idx[1:0]];

  function automatic bit near(real a, real b);
    return ((a - b) < 0.01) && ((b - a) < 0.01);
  endfunction

  task automatic check(bit ok, string tag, string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  initial begin : monitor
    forever begin
      int idx; real eh, ep; string tg; realtime t0, t1, t2;
      wait (pend > 0);
      idx = q_idx.pop_front(); eh = q_hi.pop_front();
      ep = q_per.pop_front(); tg = q_tag.pop_front();
      mon_idx = idx;
      #0.1;
      @(posedge mon_sig); @(posedge mon_sig);
      t0 = $realtime;
      @(negedge mon_sig); t1 = $realtime;
      @(posedge mon_sig); t2 = $realtime;
      check(near(t1 - t0, eh) && near(t2 - t0, ep), tg,
            $sformatf("out%0d high/period actual %0.2f/%0.2f expected %0.2f/%0.2f",
                      idx, t1 - t0, t2 - t0, eh, ep));
      pend--;
    end
  end

  task automatic expect_clk(int idx, real hi, real per, string tag);
    q_idx.push_back(idx); q_hi.push_back(hi); q_per.push_back(per); q_tag.push_back(tag);
    pend++;
    wait (pend == 0);
  endtask

  task automatic restart();
    rst_n = 1'b0;
    #21.3;
    rst_n = 1'b1;
    #60;
  endtask

  initial begin : watchdog
    #100000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual run still busy, expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    real sp [4];
    sp[0] = 4.0; sp[1] = 6.0; sp[2] = 10.0; sp[3] = 8.0;

    // R10: outputs low during reset
    #50;
    check(clk_out == 4'b0 && clk_e == 1'b0, "R10",
          $sformatf("clk_out=%b clk_e=%b expected 0000/0", clk_out, clk_e));

    // R1: each source routed to channel A, ratio 2
    for (int s = 0; s < 4; s++) begin
      rst_n = 1'b0;
      route_cfg = {6'b0, 2'(s)};
      restart();
      expect_clk(0, sp[s], 2.0 * sp[s], $sformatf("R1 src%0d", s));
    end

    // R2/R3: pass-through, wide, odd and even ratios
    rst_n = 1'b0;
    route_cfg = {2'd3, 2'd1, 2'd0, 2'd2};   // D<-s3, C<-s1, B<-s0, A<-s2
    div_a0 = 7'd1; div_a1 = 7'd1; div_b0 = 7'd127; div_b1 = 7'd127;
    div_c = 7'd3; div_d = 7'd5; e_div_cfg = 2'd0;
    restart();
    expect_clk(0, 5.0, 10.0, "R2 ratio1 pass");
    expect_clk(1, 254.0, 508.0, "R2 ratio127");
    expect_clk(2, 9.0, 18.0, "R3 ratio3");
    expect_clk(3, 20.0, 40.0, "R3 ratio5");
    // R8: fixed output codes
    expect_clk(4, 6.0, 12.0, "R8 code0");
    e_div_cfg = 2'd1; #100;
    expect_clk(4, 9.0, 18.0, "R8 code1");
    e_div_cfg = 2'd2; #100;
    expect_clk(4, 12.0, 24.0, "R8 code2");

    // R4: ratio 0 keeps channel D low
    rst_n = 1'b0;
    div_d = 7'd0;
    restart();
    begin
      bit seen_high = 0;
      for (int i = 0; i < 40; i++) begin
        #7.1;
        if (clk_out[3]) seen_high = 1;
      end
      check(!seen_high, "R4", $sformatf("out3 high seen=%0d expected 0", seen_high));
    end

    // R5/R6: profile map drives A and B together; C unaffected
    rst_n = 1'b0;
    route_cfg = {2'd2, 2'd3, 2'd0, 2'd0};
    div_a0 = 7'd2; div_a1 = 7'd3; div_b0 = 7'd4; div_b1 = 7'd6; div_c = 7'd3;
    prof_map = 8'b0110_1001;   // code0 -> reg1, code1 -> reg0
    prof_sel = 3'd0;
    restart();
    expect_clk(0, 6.0, 12.0, "R5 A reg1");
    expect_clk(1, 12.0, 24.0, "R5 B reg1");
    expect_clk(2, 12.0, 24.0, "R6 C before");
    prof_sel = 3'd1; #200;
    expect_clk(0, 4.0, 8.0, "R5 A reg0");
    expect_clk(1, 8.0, 16.0, "R5 B reg0");
    expect_clk(2, 12.0, 24.0, "R6 C after");

    // R7: every period whole old or whole new while prof_sel toggles
    begin
      bit bad = 0; real bh = 0.0, bp = 0.0;
      fork
        begin
          realtime t0, t1, t2;
          mon_idx = 0; #0.1;
          @(posedge clk_out[0]); t0 = $realtime;
          for (int i = 0; i < 30; i++) begin
            @(negedge clk_out[0]); t1 = $realtime;
            @(posedge clk_out[0]); t2 = $realtime;
            if (!((near(t2 - t0, 8.0) && near(t1 - t0, 4.0)) ||
                  (near(t2 - t0, 12.0) && near(t1 - t0, 6.0)))) begin
              bad = 1; bh = t1 - t0; bp = t2 - t0;
            end
            t0 = t2;
          end
        end
        begin
          for (int k = 0; k < 12; k++) begin
            #17.7;
            prof_sel = (prof_sel == 3'd0) ? 3'd1 : 3'd0;
          end
        end
      join
      check(!bad, "R7", $sformatf("bad high/period actual %0.2f/%0.2f expected 4/8 or 6/12", bh, bp));
    end

    // R9: A and B on synth2, ratio 2, B inverted
    rst_n = 1'b0;
    route_cfg = {2'd0, 2'd0, 2'd2, 2'd2};
    div_a0 = 7'd2; div_a1 = 7'd2; div_b0 = 7'd2; div_b1 = 7'd2;
    invert_cfg = 4'b0010;
    restart();
    begin
      realtime ta, tb;
      @(posedge clk_out[0]); ta = $realtime;
      @(posedge clk_out[1]); tb = $realtime;
      check(near(tb - ta, 5.0) || near(tb - ta, 15.0), "R9",
            $sformatf("edge offset actual %0.2f expected 5 or 15", tb - ta));
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule